// File: doc/BRIEF.md
# Bridged L2 Cache Burst Read Pipeline

This block sits between a processor front-side bus and a pipelined synchronous SRAM that holds the L2 cache. The SRAM runs on the block's own clock `clk_i`, and the bus clock is derived from it at a fixed ratio of 2 or 4. Every SRAM word packs a valid bit, a tag and a data word, so one SRAM read returns both the data and the means to decide whether it is a hit.

When the processor starts a read, the bridge registers the address and drives the line index to the SRAM. The SRAM takes two more clock edges to return the word. The bridge registers that word on the third edge, compares the tag, and presents hit data with a ready pulse. The processor samples the data on the fourth edge. A read is always a four-beat burst in linear wrap order. With the SRAM clock at twice the bus clock, this gives 3-1-1-1 bus timing. At four times the bus clock, it gives 2-1-1-1.

A miss raises a miss pulse instead of ready, and the rest of the burst is abandoned so that the access can go to main memory. Line fill, write-back and snooping are handled elsewhere.

Top module: `l2b_bridge`

## Requirements
- R1: `bus_clk_o` is high for the first RATIO/2 clock cycles of each bus period and low for the rest. It rises exactly every RATIO cycles of `clk_i`. The clock edge at which it rises is a bus edge. After reset `bus_clk_o` is high, and the first bus edge is the RATIO-th clock edge.
- R2: `ads_i` is looked at only on bus edges. At a bus edge with no access in progress and `ads_i` high, `sram_addr_o` takes `addr_i[IDX_W-1:0]` and `sram_ce_o` is high for the following clock cycle only.
- R3: An accepted access issues four SRAM reads, one at each of four consecutive bus edges starting with the accepting one. Beat k keeps `addr_i[IDX_W-1:2]` and uses low index bits `(addr_i[1:0] + k) mod 4`.
- R4: A beat read is registered on the third clock edge after its issue edge. `rdy_o` or `miss_o` is then high for exactly one clock cycle, which ends at the next bus edge (clock cycle 4 after issue). With RATIO 2 this gives 3-1-1-1 bus timing, and with RATIO 4 it gives 2-1-1-1.
- R5: The SRAM word is `{valid, tag, data}`: data in bits `[DATA_W-1:0]`, tag in the next `ADDR_W-IDX_W` bits, and the valid bit at the top. A beat hits when valid is 1 and the tag equals `addr_i[ADDR_W-1:IDX_W]` of the access. On a hit, `rd_data_o` carries the data while `rdy_o` is high.
- R6: On a missing beat, `miss_o` pulses once. `rdy_o` is not raised for that beat or any later beat of the access. No SRAM read is issued at or after the bus edge that follows the miss pulse.
- R7: While an access is in progress, `ads_i` and `addr_i` are ignored. An access is in progress from its accepting edge up to and including the bus edge where its last ready or its miss is sampled.
- R8: While `rst_ni` is low, `rdy_o`, `miss_o`, `sram_ce_o` and `rd_data_o` are 0.
- R9: A new access is accepted at the first bus edge after the one where the previous access's last ready or miss was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | SRAM-rate clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_clk_o | output | 1 | Derived bus clock, `clk_i` divided by RATIO |
| ads_i | input | 1 | Access start strobe from the processor |
| addr_i | input | ADDR_W | Processor word address |
| rdy_o | output | 1 | Hit data valid pulse for one beat |
| miss_o | output | 1 | Miss pulse; access left to main memory |
| rd_data_o | output | DATA_W | Read data for the processor |
| sram_addr_o | output | IDX_W | SRAM word index |
| sram_ce_o | output | 1 | SRAM read enable for one clock |
| sram_rdata_i | input | DATA_W+ADDR_W-IDX_W+1 | SRAM read word {valid, tag, data} |

## Verification
The assertions check the cycle-level properties on every cycle:
- the bus clock rises after each bus edge;
- SRAM reads start only on bus edges;
- every ready or miss comes exactly three edges after an SRAM read and lines up with a bus edge;
- ready is a single-cycle pulse;
- nothing follows a miss, neither a further SRAM read nor another result.

Only the bench scenarios show the rest:
- the beat address order, including wrap-around;
- hit data values and the cycle-exact timing of the burst;
- misses caused by a tag mismatch and by a cleared valid bit in the middle of a burst;
- that a strobe during a burst is ignored;
- that a new access is accepted back to back.

// File: rtl/l2b_pkg.sv
package l2b_pkg;
  // clock edges from SRAM read issue to bridge capture
  localparam int unsigned SRAM_LAT = 3;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } burst_st_e;
endpackage

// File: rtl/l2b_phase.sv
module l2b_phase #(
  parameter int unsigned RATIO = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic bus_clk_o,
  output logic bus_edge_o
);
  localparam int unsigned PW = (RATIO > 2) ? $clog2(RATIO) : 1;
  localparam logic [PW-1:0] LAST = PW'(RATIO - 1);
  localparam logic [PW-1:0] HALF = PW'(RATIO / 2);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                      phase_q <= phase_q + 1'b1;
  end

  assign bus_edge_o = (phase_q == LAST);
  assign bus_clk_o  = (phase_q < HALF);

  a_r1_bus_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_edge_o |=> $rose(bus_clk_o));
endmodule

// File: rtl/l2b_issue.sv
module l2b_issue #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned IDX_W     = 6,
  parameter int unsigned BEAT_BITS = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    bus_edge_i,
  input  logic                    ads_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    done_i,
  input  logic                    abort_i,
  output logic [IDX_W-1:0]        sram_addr_o,
  output logic                    sram_ce_o,
  output logic [ADDR_W-IDX_W-1:0] tag_o,
  output logic                    last_o
);
  import l2b_pkg::*;

  localparam int unsigned BEATS = 1 << BEAT_BITS;
  localparam int unsigned CW    = BEAT_BITS + 1;

  burst_st_e            st_q;
  logic [IDX_W-1:0]     base_q;
  logic [CW-1:0]        cnt_q;
  logic [BEAT_BITS-1:0] beat_low;
  logic                 start, next;

  assign start    = bus_edge_i && (st_q == ST_IDLE) && ads_i;
  assign next     = bus_edge_i && (st_q == ST_RUN) && (cnt_q < CW'(BEATS)) && !abort_i;
  assign beat_low = base_q[BEAT_BITS-1:0] + cnt_q[BEAT_BITS-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      base_q      <= '0;
      cnt_q       <= '0;
      sram_addr_o <= '0;
      sram_ce_o   <= 1'b0;
      tag_o       <= '0;
      last_o      <= 1'b0;
    end else begin
      sram_ce_o <= start || next;
      if (start) begin
        st_q        <= ST_RUN;
        base_q      <= addr_i[IDX_W-1:0];
        cnt_q       <= CW'(1);
        sram_addr_o <= addr_i[IDX_W-1:0];
        tag_o       <= addr_i[ADDR_W-1:IDX_W];
        last_o      <= (BEATS == 1);
      end else begin
        if (next) begin
          sram_addr_o <= {base_q[IDX_W-1:BEAT_BITS], beat_low};
          cnt_q       <= cnt_q + 1'b1;
          last_o      <= (cnt_q == CW'(BEATS - 1));
        end
        if ((st_q == ST_RUN) && (done_i || abort_i)) st_q <= ST_IDLE;
      end
    end
  end

  a_r2_issue_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_ce_o |-> $past(bus_edge_i));
  a_r6_no_read_after_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !sram_ce_o);
endmodule

// File: rtl/l2b_check.sv
module l2b_check #(
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned DATA_W = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      ce_i,
  input  logic [TAG_W-1:0]          tag_i,
  input  logic                      last_i,
  input  logic [DATA_W+TAG_W:0]     sram_rdata_i,
  output logic                      rdy_o,
  output logic                      miss_o,
  output logic                      done_o,
  output logic [DATA_W-1:0]         rd_data_o
);
  localparam int unsigned WORD_W = DATA_W + TAG_W + 1;
  localparam int unsigned DEPTH  = l2b_pkg::SRAM_LAT - 1;

  logic             v_q    [DEPTH];
  logic [TAG_W-1:0] tag_q  [DEPTH];
  logic             last_q [DEPTH];

  logic              cap_v, cap_last, hit;
  logic [TAG_W-1:0]  cap_tag;
  logic [WORD_W-1:0] cap_word;

  // in-flight tracking of beats while the SRAM works; a miss flushes them
  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic             v_in, last_in;
    logic [TAG_W-1:0] tag_in;
    if (s == 0) begin : g_head
      assign v_in    = ce_i;
      assign tag_in  = tag_i;
      assign last_in = last_i;
    end else begin : g_body
      assign v_in    = v_q[s-1];
      assign tag_in  = tag_q[s-1];
      assign last_in = last_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q[s]    <= 1'b0;
        tag_q[s]  <= '0;
        last_q[s] <= 1'b0;
      end else begin
        v_q[s]    <= v_in && !miss_o;
        tag_q[s]  <= tag_in;
        last_q[s] <= last_in;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_v    <= 1'b0;
      cap_last <= 1'b0;
      cap_tag  <= '0;
      cap_word <= '0;
    end else begin
      cap_v    <= v_q[DEPTH-1] && !miss_o;
      cap_last <= last_q[DEPTH-1];
      cap_tag  <= tag_q[DEPTH-1];
      if (v_q[DEPTH-1]) cap_word <= sram_rdata_i;
    end
  end

  assign hit       = cap_word[WORD_W-1] && (cap_word[DATA_W +: TAG_W] == cap_tag);
  assign rdy_o     = cap_v && hit;
  assign miss_o    = cap_v && !hit;
  assign done_o    = rdy_o && cap_last;
  assign rd_data_o = cap_word[DATA_W-1:0];

  a_r4_rdy_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |=> !rdy_o);
  a_r6_quiet_after_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |=> !(rdy_o || miss_o));
endmodule

// File: rtl/l2b_bridge.sv
module l2b_bridge #(
  parameter int unsigned RATIO     = 2,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned IDX_W     = 6,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned BEAT_BITS = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  output logic                           bus_clk_o,
  input  logic                           ads_i,
  input  logic [ADDR_W-1:0]              addr_i,
  output logic                           rdy_o,
  output logic                           miss_o,
  output logic [DATA_W-1:0]              rd_data_o,
  output logic [IDX_W-1:0]               sram_addr_o,
  output logic                           sram_ce_o,
  input  logic [DATA_W+ADDR_W-IDX_W:0]   sram_rdata_i
);
  localparam int unsigned TAG_W = ADDR_W - IDX_W;

  logic             bus_edge, done, iss_last;
  logic [TAG_W-1:0] iss_tag;

  l2b_phase #(.RATIO(RATIO)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_clk_o  (bus_clk_o),
    .bus_edge_o (bus_edge)
  );

  l2b_issue #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BEAT_BITS(BEAT_BITS)) u_issue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_edge_i  (bus_edge),
    .ads_i       (ads_i),
    .addr_i      (addr_i),
    .done_i      (done),
    .abort_i     (miss_o),
    .sram_addr_o (sram_addr_o),
    .sram_ce_o   (sram_ce_o),
    .tag_o       (iss_tag),
    .last_o      (iss_last)
  );

  l2b_check #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_check (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ce_i         (sram_ce_o),
    .tag_i        (iss_tag),
    .last_i       (iss_last),
    .sram_rdata_i (sram_rdata_i),
    .rdy_o        (rdy_o),
    .miss_o       (miss_o),
    .done_o       (done),
    .rd_data_o    (rd_data_o)
  );

  a_r4_result_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o || miss_o) |-> $past(sram_ce_o, l2b_pkg::SRAM_LAT));
  a_r4_result_at_bus_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o || miss_o) |-> bus_edge);
endmodule

// File: tb/l2b_bridge_bench.sv
module l2b_bridge_bench;
  localparam int RATIO  = 2;
  localparam int ADDR_W = 12;
  localparam int IDX_W  = 6;
  localparam int DATA_W = 16;
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int WORD_W = DATA_W + TAG_W + 1;

  typedef struct {
    bit          is_miss;
    logic [15:0] data;
    int          cyc;
    int          req;
  } res_t;

  typedef struct {
    logic [5:0] idx;
    int         cyc;
    int         req;
  } iss_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ads = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic bus_clk, rdy, miss, sram_ce;
  logic [DATA_W-1:0] rd_data;
  logic [IDX_W-1:0] sram_addr;
  logic [WORD_W-1:0] sram_rdata = '0;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int last_rise = -1;
  bit ended = 0;
  logic prev_bclk = 1'b1;

  res_t rq[$];
  iss_t aq[$];
  logic [WORD_W-1:0] mem [64];
  logic m_v1 = 1'b0;
  logic [IDX_W-1:0] m_a1 = '0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  l2b_bridge #(.RATIO(RATIO), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_l2b_bridge (
    .clk_i(clk), .rst_ni(rst_n), .bus_clk_o(bus_clk), .ads_i(ads), .addr_i(addr),
    .rdy_o(rdy), .miss_o(miss), .rd_data_o(rd_data), .sram_addr_o(sram_addr),
    .sram_ce_o(sram_ce), .sram_rdata_i(sram_rdata)
  );

  // two-stage pipelined SRAM model
  always @(posedge clk) begin
    m_v1 <= sram_ce;
    m_a1 <= sram_addr;
    sram_rdata <= m_v1 ? mem[m_a1] : '0;
  end

  function automatic logic [5:0] line_tag(int i);
    return 6'((i >> 2) * 5 + 3);
  endfunction

  function automatic logic [15:0] data_of(int i);
    return 16'(i * 16'h0931 + 16'h1c07);
  endfunction

  function automatic logic [11:0] mk_addr(int line, int off);
    return {line_tag(line * 4), 6'(line * 4 + off)};
  endfunction

  task automatic chk(input bit ok, input int req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // bench-side bus edge: wait for the negedge right after bus_clk rises
  task automatic bus_edge();
    logic p;
    do begin
      p = bus_clk;
      @(negedge clk);
    end while (!(bus_clk && !p));
  endtask

  task automatic do_read(input logic [11:0] a, input bit intrude, input logic [11:0] other,
                         input int first_req);
    int s;
    int m;
    bus_edge();
    ads = 1'b1;
    addr = a;
    s = cyc + RATIO;
    m = -1;
    for (int k = 0; k < 4; k++) begin
      logic [5:0] idx;
      logic [WORD_W-1:0] w;
      res_t r;
      if (m < 0) begin
        idx = {a[5:2], 2'(a[1:0] + 2'(k))};
        w = mem[idx];
        r.cyc = s + 3 + k * RATIO;
        if (w[WORD_W-1] && w[DATA_W +: TAG_W] == a[11:6]) begin
          r.is_miss = 0; r.data = w[15:0]; r.req = 5;
        end else begin
          r.is_miss = 1; r.data = '0; r.req = 6; m = k;
        end
        rq.push_back(r);
      end
    end
    for (int j = 0; j < 4; j++) begin
      iss_t e;
      if (m < 0 || j * RATIO < 4 + m * RATIO) begin
        e.idx = {a[5:2], 2'(a[1:0] + 2'(j))};
        e.cyc = s + j * RATIO;
        e.req = (j == 0) ? first_req : 3;
        aq.push_back(e);
      end
    end
    bus_edge();
    if (intrude) begin
      addr = other;  // R7: strobe held during the burst with a different line
      bus_edge();
    end
    ads = 1'b0;
    wait (rq.size() == 0 && aq.size() == 0);
  endtask

  // monitor: compares outputs against the scoreboard at every negedge
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_clk && !prev_bclk) begin
        if (last_rise >= 0) chk(cyc - last_rise == RATIO, 1, "bus clock period", cyc - last_rise, RATIO);
        last_rise = cyc;
      end
      if (rdy || miss) begin
        if (rq.size() == 0) begin
          chk(0, 6, "unexpected rdy/miss (R7)", {rdy, miss}, 0);
        end else begin
          res_t r;
          r = rq.pop_front();
          chk(miss == r.is_miss && rdy == !r.is_miss, r.req, "hit/miss", {rdy, miss}, {!r.is_miss, r.is_miss});
          chk(cyc == r.cyc, 4, "result cycle", cyc, r.cyc);
          if (!r.is_miss) chk(rd_data == r.data, 5, "read data", rd_data, r.data);
        end
      end
      if (sram_ce) begin
        if (aq.size() == 0) begin
          chk(0, 7, "unexpected SRAM read (R6)", sram_addr, 0);
        end else begin
          iss_t e;
          e = aq.pop_front();
          chk(sram_addr == e.idx, e.req, "SRAM index", sram_addr, e.idx);
          chk(cyc == e.cyc, e.req, "SRAM issue cycle", cyc, e.cyc);
        end
      end
    end
    prev_bclk = bus_clk;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R9 watchdog: actual=hung expected=complete");
    summary();
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = {1'b1, line_tag(i), data_of(i)};
    repeat (3) @(negedge clk);
    // R8: outputs quiet in reset
    chk(rdy == 0 && miss == 0 && sram_ce == 0, 8, "reset controls", {rdy, miss, sram_ce}, 0);
    chk(rd_data == 0, 8, "reset data", rd_data, 0);
    chk(bus_clk == 1, 1, "bus clock in reset", bus_clk, 1);
    rst_n = 1'b1;
    prev_bclk = bus_clk;
    // R3 R4 R5: aligned hit burst
    do_read(mk_addr(2, 0), 0, '0, 2);
    // R3: wrap order starting at offset 2, back to back (R9)
    do_read(mk_addr(5, 2), 0, '0, 9);
    do_read(mk_addr(9, 3), 0, '0, 9);
    // R6: tag mismatch on first beat
    do_read({6'h3f, 6'(7 * 4 + 1)}, 0, '0, 2);
    // R5 R6: valid bit cleared on third beat
    mem[11 * 4 + 2][WORD_W-1] = 1'b0;
    do_read(mk_addr(11, 0), 0, '0, 9);
    // R6: tag mismatch on last beat of a wrapped burst
    mem[13 * 4 + 0][DATA_W +: TAG_W] = 6'h00;
    do_read(mk_addr(13, 1), 0, '0, 9);
    // R7: strobe with another address during burst is ignored
    do_read(mk_addr(4, 1), 1, mk_addr(14, 2), 9);
    do_read(mk_addr(15, 3), 0, '0, 9);
    repeat (20) @(negedge clk);
    chk(rq.size() == 0 && aq.size() == 0, 7, "no stray activity", rq.size() + aq.size(), 0);
    summary();
  end
endmodule